// File: doc/BRIEF.md
# Audio Sample-Rate Clock Generator

This block turns a single master clock into the clocks an audio converter needs. The master clock can come from a crystal or from an external source on the same input. A three-bit ratio select says how fast the master clock runs relative to the sample rate fs. From it the block always makes a 256fs converter clock and a master/2 auxiliary clock. The top select bit picks a reduced-rate mode. In that mode the serial frame clocks run at half speed, while the converter and auxiliary clocks keep their ratio to the master clock.

A mode input sets the direction of the serial frame clocks.

- **Master:** the block drives the bit clock and the word-select clock, and asserts their output enables.
- **Slave:** the enables drop and the outputs are held low. The internal frame counter realigns to each falling edge of the incoming word-select clock. An activity check reports whether both incoming clocks are toggling.

Select and mode are captured only during a synchronous restart. All dividers begin from zero at that point.

Top module: `audio_clk_gen`

## Requirements
- R1: In master mode (latched `master_i`=1) `lrck_oe_o` and `bck_oe_o` are 1 and the frame clocks toggle. In slave mode both enables are 0 and `lrck_o`, `bck_o` stay 0 whatever `lrck_i`/`bck_i` do.
- R2: `conv_clk_o` has a period of d master cycles, with d = sel[1:0]+1 (00→1, 01→2, 10→3, 11→4). For code 00 it equals the master clock itself.
- R3: For d>1, `conv_clk_o` is high for floor(d/2) master cycles per period. This gives 50% for d=2 and d=4, and a one-third high phase for d=3.
- R4: `aux_clk_o` toggles on every master clock edge outside restart, giving a period of 2 master cycles for every code.
- R5: In master mode the `bck_o` period is 4·d master cycles when sel[2]=0 and 8·d when sel[2]=1, with a 50% duty cycle.
- R6: The `lrck_o` period is 64 `bck_o` periods with a 50% duty cycle. `lrck_o` changes only in the cycle where `bck_o` falls.
- R7: sel[2] does not alter the `conv_clk_o` or `aux_clk_o` period.
- R8: In master mode `frame_start_o` is high for exactly the first master cycle in which `lrck_o` is low after a high phase, and at no other time.
- R9: In slave mode a falling edge on `lrck_i` restarts the frame counter. `frame_start_o` pulses for one cycle, sampled after the third rising master edge that follows the input change, and at no other time.
- R10: In slave mode `clk_present_o` rises once both `lrck_i` and `bck_i` have toggled. It falls when either has been idle for PRESENT_TO (default 4096) master cycles. In master mode it is 0.
- R11: `sel_i` and `master_i` are taken only while `srst_i` is 1, and later changes have no effect. During `srst_i` the aux clock, frame clocks and `frame_start_o` are 0.
- R12: While `rst_ni` is 0 the block is in slave mode with code 000. All outputs are 0 except `conv_clk_o`, which follows the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (crystal or external) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous restart; captures configuration |
| sel_i | input | 3 | Ratio select: [1:0] master/fs ratio, [2] reduced-rate mode |
| master_i | input | 1 | 1 = drive frame clocks, 0 = accept them |
| lrck_i | input | 1 | Incoming word-select clock (slave) |
| bck_i | input | 1 | Incoming bit clock (slave) |
| conv_clk_o | output | 1 | 256fs converter clock |
| aux_clk_o | output | 1 | Master clock divided by 2 |
| lrck_o | output | 1 | Word-select clock out (master) |
| bck_o | output | 1 | Bit clock out (master) |
| lrck_oe_o | output | 1 | Output enable for word-select pin |
| bck_oe_o | output | 1 | Output enable for bit clock pin |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| clk_present_o | output | 1 | Incoming frame clocks active (slave) |

## Verification
Some properties are checked on every cycle:
- the aux clock toggling;
- the word-select clock moving only with a falling bit clock;
- the frame pulse accompanying each word-select fall and lasting one cycle;
- the quiet frame outputs and absent activity flag in slave and master respectively;
- the quiet outputs after restart.

Other behaviour only the bench scenarios can show. This covers the actual periods and duty cycles for each of the eight codes in both modes, and the pass-through clock for code 00. It also covers the three-edge latency of slave realignment, the activity timeout, and the fact that select changes outside restart are ignored.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } acg_mode_e;

  // index of the reference signal inside the activity monitor vector
  localparam int unsigned MON_LRCK = 0;
  localparam int unsigned MON_BCK  = 1;
  localparam int unsigned MON_N    = 2;
endpackage

// File: rtl/acg_mclk_div.sv
`timescale 1ns/1ps
module acg_mclk_div #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             tick_o,
  output logic             conv_clk_o,
  output logic             aux_clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic [DIV_W:0]   half;
  logic             conv_q, aux_q;

  assign tick_o  = (cnt_q == div_m1_i);
  assign cnt_nxt = tick_o ? '0 : cnt_q + 1'b1;
  assign half    = ({1'b0, div_m1_i} + 1'b1) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      conv_q <= 1'b0;
      aux_q  <= 1'b0;
    end else if (srst_i) begin
      cnt_q  <= '0;
      conv_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      conv_q <= ({1'b0, cnt_nxt} < half);
      aux_q  <= ~aux_q;
    end
  end

  // ratio 1: master clock is already 256fs
  assign conv_clk_o = (div_m1_i == '0) ? clk_i : conv_q;
  assign aux_clk_o  = aux_q;
endmodule

// File: rtl/acg_frame_gen.sv
`timescale 1ns/1ps
module acg_frame_gen #(
  parameter int unsigned BCK_LOG2   = 2,
  parameter int unsigned FRAME_LOG2 = 6,
  localparam int unsigned FCNT_W    = BCK_LOG2 + FRAME_LOG2 + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic tick_i,
  input  logic low_rate_i,
  input  logic master_i,
  input  logic resync_i,
  output logic bck_o,
  output logic lrck_o,
  output logic frame_o
);
  logic [FCNT_W-1:0] fcnt_q;
  logic              fr_q;
  logic              wrap, bck_bit, lrck_bit;

  // reduced rate shifts both taps up one stage
  assign bck_bit  = low_rate_i ? fcnt_q[BCK_LOG2]          : fcnt_q[BCK_LOG2-1];
  assign lrck_bit = low_rate_i ? fcnt_q[FCNT_W-1]          : fcnt_q[FCNT_W-2];
  assign wrap     = low_rate_i ? (&fcnt_q) : (&fcnt_q[FCNT_W-2:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q <= '0;
      fr_q   <= 1'b0;
    end else if (srst_i) begin
      fcnt_q <= '0;
      fr_q   <= 1'b0;
    end else begin
      if (!master_i && resync_i) fcnt_q <= '0;
      else if (tick_i)           fcnt_q <= fcnt_q + 1'b1;
      fr_q <= master_i ? (tick_i & wrap) : resync_i;
    end
  end

  assign bck_o   = master_i & bck_bit;
  assign lrck_o  = master_i & lrck_bit;
  assign frame_o = fr_q;
endmodule

// File: rtl/acg_activity_mon.sv
`timescale 1ns/1ps
module acg_activity_mon #(
  parameter int unsigned N       = 2,
  parameter int unsigned TIMEOUT = 4096,
  localparam int unsigned TW     = $clog2(TIMEOUT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] sig_i,
  output logic         present_o,
  output logic         fall0_o
);
  logic [N-1:0] s1_q, s2_q, s3_q, act_q, edge_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= sig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_d = s2_q ^ s3_q;

  for (genvar i = 0; i < N; i++) begin : g_mon
    logic [TW-1:0] tmr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tmr_q    <= '0;
        act_q[i] <= 1'b0;
      end else if (clr_i) begin
        tmr_q    <= '0;
        act_q[i] <= 1'b0;
      end else if (edge_d[i]) begin
        tmr_q    <= '0;
        act_q[i] <= 1'b1;
      end else if (act_q[i]) begin
        if (tmr_q == TW'(TIMEOUT - 1)) act_q[i] <= 1'b0;
        else                           tmr_q    <= tmr_q + 1'b1;
      end
    end
  end

  assign present_o = &act_q;
  assign fall0_o   = s3_q[0] & ~s2_q[0];
endmodule

// File: rtl/audio_clk_gen.sv
`timescale 1ns/1ps
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int unsigned DIV_W      = 2,
  parameter int unsigned BCK_LOG2   = 2,
  parameter int unsigned FRAME_LOG2 = 6,
  parameter int unsigned PRESENT_TO = 4096,
  localparam int unsigned SEL_W     = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             master_i,
  input  logic             lrck_i,
  input  logic             bck_i,
  output logic             conv_clk_o,
  output logic             aux_clk_o,
  output logic             lrck_o,
  output logic             bck_o,
  output logic             lrck_oe_o,
  output logic             bck_oe_o,
  output logic             frame_start_o,
  output logic             clk_present_o
);
  logic [SEL_W-1:0] sel_q;
  acg_mode_e        mode_q;
  logic             tick, is_master, resync, mon_clr;
  logic [MON_N-1:0] mon_sig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= MODE_SLAVE;
    end else if (srst_i) begin
      sel_q  <= sel_i;
      mode_q <= acg_mode_e'(master_i);
    end
  end

  assign is_master = (mode_q == MODE_MASTER);

  acg_mclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_i),
    .div_m1_i   (sel_q[DIV_W-1:0]),
    .tick_o     (tick),
    .conv_clk_o (conv_clk_o),
    .aux_clk_o  (aux_clk_o)
  );

  acg_frame_gen #(.BCK_LOG2(BCK_LOG2), .FRAME_LOG2(FRAME_LOG2)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_i),
    .tick_i     (tick),
    .low_rate_i (sel_q[SEL_W-1]),
    .master_i   (is_master),
    .resync_i   (resync),
    .bck_o      (bck_o),
    .lrck_o     (lrck_o),
    .frame_o    (frame_start_o)
  );

  always_comb begin
    mon_sig           = '0;
    mon_sig[MON_LRCK] = lrck_i;
    mon_sig[MON_BCK]  = bck_i;
  end
  assign mon_clr = srst_i | is_master;

  acg_activity_mon #(.N(MON_N), .TIMEOUT(PRESENT_TO)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (mon_clr),
    .sig_i     (mon_sig),
    .present_o (clk_present_o),
    .fall0_o   (resync)
  );

  assign lrck_oe_o = is_master;
  assign bck_oe_o  = is_master;
endmodule

// File: rtl/acg_checker.sv
`timescale 1ns/1ps
module acg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic aux_clk_o,
  input logic lrck_o,
  input logic bck_o,
  input logic lrck_oe_o,
  input logic frame_start_o,
  input logic clk_present_o
);
  a_r1_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lrck_oe_o |-> (!lrck_o && !bck_o));

  a_r4_aux_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(srst_i) |-> (aux_clk_o != $past(aux_clk_o)));

  a_r6_lrck_on_bck_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(srst_i) && (lrck_o != $past(lrck_o))) |-> ($past(bck_o) && !bck_o));

  a_r8_frame_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(srst_i) && $fell(lrck_o)) |-> frame_start_o);

  a_r8_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  a_r10_no_present_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrck_oe_o |-> !clk_present_o);

  a_r11_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!aux_clk_o && !bck_o && !lrck_o && !frame_start_o));
endmodule

bind audio_clk_gen acg_checker u_acg_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .srst_i        (srst_i),
  .aux_clk_o     (aux_clk_o),
  .lrck_o        (lrck_o),
  .bck_o         (bck_o),
  .lrck_oe_o     (lrck_oe_o),
  .frame_start_o (frame_start_o),
  .clk_present_o (clk_present_o)
);

// File: tb/tb_audio_clk_gen.sv
`timescale 1ns/1ps
module tb_audio_clk_gen;
  localparam int TO = 4096;

  logic       clk = 1'b0, rst_n = 1'b0, srst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       ms = 1'b0, lrck_in = 1'b0, bck_in = 1'b0;
  logic       conv, aux, lrck, bck, lrck_oe, bck_oe, fs, present;
  int n_chk = 0, n_fail = 0;

  audio_clk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .sel_i(sel), .master_i(ms),
    .lrck_i(lrck_in), .bck_i(bck_in), .conv_clk_o(conv), .aux_clk_o(aux),
    .lrck_o(lrck), .bck_o(bck), .lrck_oe_o(lrck_oe), .bck_oe_o(bck_oe),
    .frame_start_o(fs), .clk_present_o(present)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int f_div(input logic [2:0] s);
    return int'(s[1:0]) + 1;
  endfunction
  function automatic int f_bck(input logic [2:0] s);
    return f_div(s) * (s[2] ? 8 : 4);
  endfunction

  // restart with a configuration, then scramble the inputs (R11)
  task automatic apply(input logic [2:0] s, input logic m);
    sel = s; ms = m; srst = 1'b1;
    repeat (3) step();
    chk(!aux && !bck && !lrck && !fs, "R11", "outputs quiet in restart",
        int'({aux, bck, lrck, fs}), 0);
    srst = 1'b0;
    sel = 3'($urandom); ms = 1'($urandom);
  endtask

  task automatic run_cfg(input logic [2:0] s, input logic m);
    int  d, ncyc;
    int  rise[4], nr[4], per[4], hrun[4], hlast[4];
    logic pv[4], v[4];
    int  rule_err, fs_err, pres_hi, slave_act;
    d = f_div(s);
    apply(s, m);
    ncyc = m ? 2 * 64 * f_bck(s) + 8 : 64;
    foreach (pv[i]) begin
      pv[i] = 1'b0; rise[i] = 0; nr[i] = 0; per[i] = 0; hrun[i] = 0; hlast[i] = 0;
    end
    rule_err = 0; fs_err = 0; pres_hi = 0; slave_act = 0;
    for (int c = 0; c < ncyc; c++) begin
      lrck_in = 1'($urandom); bck_in = 1'($urandom);
      step();
      v[0] = conv; v[1] = aux; v[2] = bck; v[3] = lrck;
      if (m) begin
        if ((lrck != pv[3]) && !(pv[2] && !bck)) rule_err++;
        if (fs != (pv[3] && !lrck)) fs_err++;
      end else if (lrck || bck) slave_act++;
      if (present) pres_hi++;
      for (int i = 0; i < 4; i++) begin
        if (v[i] && !pv[i]) begin
          if (nr[i] > 0) begin
            per[i] = c - rise[i];
            hlast[i] = hrun[i];
          end
          rise[i] = c; nr[i]++; hrun[i] = 0;
        end
        if (v[i]) hrun[i]++;
        pv[i] = v[i];
      end
    end
    if (d == 1) begin
      chk(conv === 1'b1, "R2", "code 00 pass-through high", int'(conv), 1);
      @(negedge clk); #1;
      chk(conv === 1'b0, "R2", "code 00 pass-through low", int'(conv), 0);
    end else begin
      chk(per[0] == d, "R2", "conv period", per[0], d);
      chk(hlast[0] == d / 2, "R3", "conv high time", hlast[0], d / 2);
    end
    chk(per[1] == 2 && hlast[1] == 1, "R4/R7", "aux period", per[1], 2);
    if (m) begin
      chk(lrck_oe && bck_oe, "R1", "master enables", int'({lrck_oe, bck_oe}), 3);
      chk(per[2] == f_bck(s), "R5", "bck period", per[2], f_bck(s));
      chk(hlast[2] == f_bck(s) / 2, "R5", "bck high", hlast[2], f_bck(s) / 2);
      chk(per[3] == 64 * f_bck(s), "R6", "lrck period", per[3], 64 * f_bck(s));
      chk(hlast[3] == 32 * f_bck(s), "R6", "lrck high", hlast[3], 32 * f_bck(s));
      chk(rule_err == 0, "R6", "lrck moved off bck fall", rule_err, 0);
      chk(fs_err == 0, "R8", "frame pulse mismatches", fs_err, 0);
      chk(pres_hi == 0, "R10", "present in master", pres_hi, 0);
    end else begin
      chk(!lrck_oe && !bck_oe, "R1", "slave enables", int'({lrck_oe, bck_oe}), 0);
      chk(slave_act == 0, "R1", "slave frame outputs active", slave_act, 0);
    end
  endtask

  task automatic slave_sync();
    bit fell_h[0:520];
    logic prev_l;
    int fs_err;
    apply(3'b001, 1'b0);
    lrck_in = 1'b0; bck_in = 1'b0; prev_l = 1'b0; fs_err = 0;
    for (int n = 0; n < 512; n++) begin
      bck_in  = 1'((n / 2) % 2);
      lrck_in = 1'((n / 64) % 2);
      fell_h[n] = prev_l && !lrck_in;
      prev_l = lrck_in;
      step();
      if (fs != ((n + 1 >= 3) ? fell_h[n - 2] : 1'b0)) fs_err++;
    end
    chk(fs_err == 0, "R9", "slave frame pulse timing", fs_err, 0);
    chk(present == 1'b1, "R10", "present while toggling", int'(present), 1);
    repeat (TO + 10) step();
    chk(present == 1'b0, "R10", "present after idle", int'(present), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd5417));
    repeat (4) step();
    chk(!aux && !lrck && !bck && !lrck_oe && !bck_oe && !fs && !present, "R12",
        "reset outputs", int'({aux, lrck, bck, lrck_oe, bck_oe, fs, present}), 0);
    chk(conv === 1'b1, "R12", "conv follows clock in reset", int'(conv), 1);
    rst_n = 1'b1;
    repeat (2) step();
    for (int k = 0; k < 16; k++) run_cfg(3'(k % 8), 1'(k / 8));
    for (int k = 0; k < 6; k++) run_cfg(3'($urandom), 1'($urandom));
    slave_sync();
    summary();
  end
endmodule